// File: doc/BRIEF.md
# Multichannel DAC SPI Command Controller

This block is a hardware master that drives register commands to a 40-channel, 14-bit serial DAC. A requester presents a command on a valid/ready port. The command holds an operation code, a register-select mode, a channel, a read flag and a data word. The block packs the command into a 24-bit word and holds an active-high chip select around it. It then shifts the word out MSB first in SPI mode 1: the serial clock idles low, the output changes on the rising edge and the input is sampled on the falling edge.

A readback takes two chip-select frames. The first is the command frame with the read flag set. Chip select then stays low for a programmable gap, and a second frame of all zeros follows. The low 16 bits captured during the second frame are returned with a one-cycle valid pulse.

Four helper operations issue fixed special-function words so that the requester does not have to assemble them: soft clear, soft reset, and two control-register setups. Raw commands that address a channel beyond the last one are refused without touching the bus. The serial clock rate and the readback gap are set by system-clock divide parameters.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: A raw command (req_op 0) produces one 24-bit frame, sent MSB first. Bit 22 is the read flag, bits 20:16 are the low 5 bits of req_chan, bits 15:14 are req_mode and bits 13:0 are the data. Bits 23 and 21 are zero.
- R2: Only req_data[13:0] enters the frame; req_data[15:14] never reach the bus.
- R3: The following commands are refused: a raw command with req_chan greater than 39, and any req_op value from 5 to 7. For a refused command, cmd_reject is high in the cycle after the handshake, no frame is sent and req_ready stays high.
- R4: The bus runs SPI mode 1. spi_sclk idles low and each frame has exactly 24 rising edges. spi_mosi changes only on a rising edge. Every interval between chip-select edges and clock edges inside a frame lasts CLK_DIV system clocks.
- R5: spi_cs is high for the whole of each frame and low between frames. spi_sclk is low whenever spi_cs is low.
- R6: A raw command with req_read set sends its command frame, then holds spi_cs low for at least GAP_CYCLES system clocks, then sends a second frame of all zeros.
- R7: When the second frame of a readback ends, rd_valid pulses high for exactly one cycle. rd_data then carries the last 16 bits sampled from spi_miso during that frame.
- R8: req_ready is low from the handshake until the last frame of the command has ended, including the readback gap. It is high whenever the block is idle.
- R9: Helper operations ignore req_mode, req_chan, req_data and req_read and send one write frame with mode 0. The frames are: op 1 (soft clear) 0x022000, op 2 (soft reset) 0x0F211F, op 3 (control setup with the 2.5 V internal reference) 0x0C1400, op 4 (control setup with the 1.25 V internal reference) 0x0C0400.
- R10: After reset, spi_cs, spi_sclk, spi_mosi, rd_valid and cmd_reject are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Block idle and able to accept a command |
| req_op | input | 3 | Operation: 0 raw, 1 soft clear, 2 soft reset, 3 control setup 2.5 V, 4 control setup 1.25 V |
| req_mode | input | 2 | Register select: 3 input data, 2 offset, 1 gain, 0 special function |
| req_chan | input | 6 | Channel or special-function address |
| req_read | input | 1 | Raw command is a readback |
| req_data | input | 16 | Write data; only the low 14 bits are used |
| cmd_reject | output | 1 | One-cycle pulse for a refused command |
| rd_valid | output | 1 | One-cycle pulse when readback data is ready |
| rd_data | output | 16 | Readback value |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the DAC |
| spi_miso | input | 1 | Serial data from the DAC |
| spi_cs | output | 1 | Chip select, active high |

## Verification
Chip select rises two system clocks after the handshake: one cycle registers the start, and the shifter raises spi_cs on the next. A frame then lasts 49 intervals of CLK_DIV clocks each. cmd_reject is due one cycle after the handshake. rd_valid is due one cycle after the NOP frame's chip select falls. req_ready returns one cycle after the last chip-select fall. The scoreboard does not count cycles for bus results: it compares each frame when chip select falls, and each readback value in the cycle where rd_valid is sampled on a falling system-clock edge. The reject and busy checks wait a fixed number of falling edges past the handshake or past the first frame. Clock intervals and the readback gap are measured in simulation time, so the checks do not depend on how the design's registers line up against the bench.

// File: rtl/dac_cmd_pkg.sv
`timescale 1ns/1ps
package dac_cmd_pkg;

  typedef enum logic [2:0] {
    OP_RAW         = 3'd0,
    OP_SOFT_CLR    = 3'd1,
    OP_SOFT_RST    = 3'd2,
    OP_INIT_REF_HI = 3'd3,
    OP_INIT_REF_LO = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CMD,
    SQ_GAP,
    SQ_NOP
  } seq_state_e;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_RUN,
    SH_TAIL
  } shift_state_e;

  // special-function register select and its fixed addresses / words
  localparam logic [1:0]  SEL_SPECIAL        = 2'd0;
  localparam logic [4:0]  SPC_ADDR_SOFT_CLR  = 5'h02;
  localparam logic [4:0]  SPC_ADDR_SOFT_RST  = 5'h0F;
  localparam logic [4:0]  SPC_ADDR_CTRL      = 5'h0C;
  localparam logic [13:0] SPC_DATA_SOFT_CLR  = 14'h2000;
  localparam logic [13:0] SPC_DATA_SOFT_RST  = 14'h211F;

  // control word bit positions decoded by the DAC
  localparam int CTRL_BIT_REF_2V5 = 12;
  localparam int CTRL_BIT_REF_INT = 10;

endpackage

// File: rtl/dac_rst_sync.sv
`timescale 1ns/1ps
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dac_frame_build.sv
`timescale 1ns/1ps
module dac_frame_build
  import dac_cmd_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int CH_IN_W = 6,
  parameter int CH_W    = 5,
  parameter int NUM_CH  = 40,
  parameter int MODE_W  = 2,
  parameter int DATA_W  = 14,
  parameter int IN_W    = 16
) (
  input  logic [2:0]         op,
  input  logic [MODE_W-1:0]  mode,
  input  logic [CH_IN_W-1:0] chan,
  input  logic               rd,
  input  logic [IN_W-1:0]    data,
  output logic [FRAME_W-1:0] frame,
  output logic               is_read,
  output logic               accept_ok
);

  localparam int MODE_LSB = DATA_W;
  localparam int CH_LSB   = DATA_W + MODE_W;
  localparam int RD_BIT   = CH_LSB + CH_W + 1;

  logic [MODE_W-1:0] sel;
  logic [CH_W-1:0]   addr;
  logic [DATA_W-1:0] payload;
  logic [DATA_W-1:0] ctrl_word;
  logic              unused_data_hi;

  assign unused_data_hi = ^data[IN_W-1:DATA_W];

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[CTRL_BIT_REF_INT] = 1'b1;
    ctrl_word[CTRL_BIT_REF_2V5] = (op == OP_INIT_REF_HI);
  end

  always_comb begin
    sel       = MODE_W'(SEL_SPECIAL);
    addr      = '0;
    payload   = '0;
    is_read   = 1'b0;
    accept_ok = 1'b0;
    case (op)
      OP_RAW: begin
        sel       = mode;
        addr      = chan[CH_W-1:0];
        payload   = data[DATA_W-1:0];
        is_read   = rd;
        accept_ok = (chan < CH_IN_W'(NUM_CH));
      end
      OP_SOFT_CLR: begin
        addr      = CH_W'(SPC_ADDR_SOFT_CLR);
        payload   = DATA_W'(SPC_DATA_SOFT_CLR);
        accept_ok = 1'b1;
      end
      OP_SOFT_RST: begin
        addr      = CH_W'(SPC_ADDR_SOFT_RST);
        payload   = DATA_W'(SPC_DATA_SOFT_RST);
        accept_ok = 1'b1;
      end
      OP_INIT_REF_HI, OP_INIT_REF_LO: begin
        addr      = CH_W'(SPC_ADDR_CTRL);
        payload   = ctrl_word;
        accept_ok = 1'b1;
      end
      default: accept_ok = 1'b0;
    endcase
  end

  always_comb begin
    frame                      = '0;
    frame[DATA_W-1:0]          = payload;
    frame[MODE_LSB +: MODE_W]  = sel;
    frame[CH_LSB +: CH_W]      = addr;
    frame[RD_BIT]              = is_read;
  end

endmodule

// File: rtl/dac_spi_shift.sv
`timescale 1ns/1ps
module dac_spi_shift
  import dac_cmd_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int CLK_DIV = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               cs,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word
);

  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  shift_state_e       state_q, state_n;
  logic [DIV_W-1:0]   div_q, div_n;
  logic [BIT_W-1:0]   bit_q, bit_n;
  logic [FRAME_W-1:0] tx_q, tx_n;
  logic [FRAME_W-1:0] rx_q, rx_n;
  logic               sclk_q, sclk_n;
  logic               mosi_q, mosi_n;
  logic               cs_q, cs_n;
  logic               done_q, done_n;
  logic               tick;

  assign tick = (div_q == DIV_W'(CLK_DIV - 1));

  always_comb begin
    state_n = state_q;
    div_n   = div_q;
    bit_n   = bit_q;
    tx_n    = tx_q;
    rx_n    = rx_q;
    sclk_n  = sclk_q;
    mosi_n  = mosi_q;
    cs_n    = cs_q;
    done_n  = 1'b0;
    case (state_q)
      SH_IDLE: begin
        if (start) begin
          state_n = SH_RUN;
          cs_n    = 1'b1;
          tx_n    = tx_word;
          rx_n    = '0;
          div_n   = '0;
          bit_n   = '0;
        end
      end
      SH_RUN: begin
        if (tick) begin
          div_n = '0;
          if (!sclk_q) begin
            sclk_n = 1'b1;
            mosi_n = tx_q[FRAME_W-1];
            tx_n   = {tx_q[FRAME_W-2:0], 1'b0};
          end else begin
            sclk_n = 1'b0;
            rx_n   = {rx_q[FRAME_W-2:0], miso};
            if (bit_q == BIT_W'(FRAME_W - 1)) state_n = SH_TAIL;
            else                              bit_n   = bit_q + 1'b1;
          end
        end else begin
          div_n = div_q + 1'b1;
        end
      end
      SH_TAIL: begin
        if (tick) begin
          div_n   = '0;
          cs_n    = 1'b0;
          done_n  = 1'b1;
          state_n = SH_IDLE;
        end else begin
          div_n = div_q + 1'b1;
        end
      end
      default: state_n = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      cs_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      div_q   <= div_n;
      bit_q   <= bit_n;
      tx_q    <= tx_n;
      rx_q    <= rx_n;
      sclk_q  <= sclk_n;
      mosi_q  <= mosi_n;
      cs_q    <= cs_n;
      done_q  <= done_n;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign cs      = cs_q;
  assign done    = done_q;
  assign rx_word = rx_q;

endmodule

// File: rtl/dac_cmd_seq.sv
`timescale 1ns/1ps
module dac_cmd_seq
  import dac_cmd_pkg::*;
#(
  parameter int FRAME_W    = 24,
  parameter int GAP_CYCLES = 1000,
  parameter int RD_W       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_ok,
  input  logic               req_is_read,
  input  logic [FRAME_W-1:0] req_frame,
  output logic               req_ready,
  output logic               cmd_reject,
  output logic               sh_start,
  output logic [FRAME_W-1:0] sh_word,
  input  logic               sh_done,
  input  logic [FRAME_W-1:0] sh_rx,
  output logic               rd_valid,
  output logic [RD_W-1:0]    rd_data
);

  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  seq_state_e         state_q, state_n;
  logic [GAP_W-1:0]   gap_q, gap_n;
  logic               pend_q, pend_n;
  logic               start_q, start_n;
  logic [FRAME_W-1:0] word_q, word_n;
  logic               rej_q, rej_n;
  logic               rdv_q, rdv_n;
  logic [RD_W-1:0]    rdd_q, rdd_n;
  logic               unused_rx_hi;

  assign unused_rx_hi = ^sh_rx[FRAME_W-1:RD_W];

  always_comb begin
    state_n = state_q;
    gap_n   = gap_q;
    pend_n  = pend_q;
    start_n = 1'b0;
    word_n  = word_q;
    rej_n   = 1'b0;
    rdv_n   = 1'b0;
    rdd_n   = rdd_q;
    case (state_q)
      SQ_IDLE: begin
        if (req_valid) begin
          if (req_ok) begin
            start_n = 1'b1;
            word_n  = req_frame;
            pend_n  = req_is_read;
            state_n = SQ_CMD;
          end else begin
            rej_n = 1'b1;
          end
        end
      end
      SQ_CMD: begin
        if (sh_done) begin
          gap_n   = '0;
          state_n = pend_q ? SQ_GAP : SQ_IDLE;
        end
      end
      SQ_GAP: begin
        if (gap_q == GAP_W'(GAP_CYCLES - 1)) begin
          start_n = 1'b1;
          word_n  = '0;
          state_n = SQ_NOP;
        end else begin
          gap_n = gap_q + 1'b1;
        end
      end
      SQ_NOP: begin
        if (sh_done) begin
          rdv_n   = 1'b1;
          rdd_n   = sh_rx[RD_W-1:0];
          pend_n  = 1'b0;
          state_n = SQ_IDLE;
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      gap_q   <= '0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      word_q  <= '0;
      rej_q   <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      state_q <= state_n;
      gap_q   <= gap_n;
      pend_q  <= pend_n;
      start_q <= start_n;
      word_q  <= word_n;
      rej_q   <= rej_n;
      rdv_q   <= rdv_n;
      rdd_q   <= rdd_n;
    end
  end

  assign req_ready  = (state_q == SQ_IDLE);
  assign cmd_reject = rej_q;
  assign sh_start   = start_q;
  assign sh_word    = word_q;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;

endmodule

// File: rtl/dac_cmd_ctrl.sv
`timescale 1ns/1ps
module dac_cmd_ctrl #(
  parameter int CLK_DIV    = 5,
  parameter int GAP_CYCLES = 1000,
  parameter int NUM_CH     = 40,
  parameter int FRAME_W    = 24,
  parameter int DATA_W     = 14,
  parameter int IN_W       = 16,
  parameter int MODE_W     = 2,
  parameter int CH_W       = 5,
  parameter int CH_IN_W    = 6,
  parameter int RD_W       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic [MODE_W-1:0]  req_mode,
  input  logic [CH_IN_W-1:0] req_chan,
  input  logic               req_read,
  input  logic [IN_W-1:0]    req_data,
  output logic               cmd_reject,
  output logic               rd_valid,
  output logic [RD_W-1:0]    rd_data,
  output logic               spi_sclk,
  output logic               spi_mosi,
  input  logic               spi_miso,
  output logic               spi_cs
);

  logic               rst_n_int;
  logic [FRAME_W-1:0] bld_frame;
  logic               bld_read;
  logic               bld_ok;
  logic               sh_start;
  logic [FRAME_W-1:0] sh_word;
  logic               sh_done;
  logic [FRAME_W-1:0] sh_rx;

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dac_frame_build #(
    .FRAME_W (FRAME_W), .CH_IN_W (CH_IN_W), .CH_W (CH_W), .NUM_CH (NUM_CH),
    .MODE_W  (MODE_W),  .DATA_W  (DATA_W),  .IN_W (IN_W)
  ) u_build (
    .op        (req_op),
    .mode      (req_mode),
    .chan      (req_chan),
    .rd        (req_read),
    .data      (req_data),
    .frame     (bld_frame),
    .is_read   (bld_read),
    .accept_ok (bld_ok)
  );

  dac_cmd_seq #(
    .FRAME_W (FRAME_W), .GAP_CYCLES (GAP_CYCLES), .RD_W (RD_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req_valid   (req_valid),
    .req_ok      (bld_ok),
    .req_is_read (bld_read),
    .req_frame   (bld_frame),
    .req_ready   (req_ready),
    .cmd_reject  (cmd_reject),
    .sh_start    (sh_start),
    .sh_word     (sh_word),
    .sh_done     (sh_done),
    .sh_rx       (sh_rx),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );

  dac_spi_shift #(
    .FRAME_W (FRAME_W), .CLK_DIV (CLK_DIV)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start   (sh_start),
    .tx_word (sh_word),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .cs      (spi_cs),
    .done    (sh_done),
    .rx_word (sh_rx)
  );

endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module dac_cmd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic cmd_reject,
  input logic rd_valid,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs
);

  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs |-> !spi_sclk);

  assert_busy_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs |-> !req_ready);

  assert_mosi_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(spi_sclk) |-> $stable(spi_mosi));

  assert_reject_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> (!spi_cs && req_ready));

  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_rd_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_cs);

endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .cmd_reject (cmd_reject),
  .rd_valid   (rd_valid),
  .spi_sclk   (spi_sclk),
  .spi_mosi   (spi_mosi),
  .spi_cs     (spi_cs)
);

// File: tb/dac_cmd_ctrl_test.sv
`timescale 1ns/1ps
module dac_cmd_ctrl_test;

  localparam int CLK_DIV = 5;
  localparam int GAP     = 1000;
  localparam longint HALF_NS = CLK_DIV * 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_mode = '0;
  logic [5:0]  req_chan = '0;
  logic        req_read = 1'b0;
  logic [15:0] req_data = '0;
  logic        cmd_reject;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        spi_sclk, spi_mosi, spi_cs;
  logic        spi_miso = 1'b0;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dac_cmd_ctrl #(.CLK_DIV(CLK_DIV), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mode(req_mode), .req_chan(req_chan), .req_read(req_read),
    .req_data(req_data), .cmd_reject(cmd_reject), .rd_valid(rd_valid), .rd_data(rd_data),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  // scoreboard queues
  logic [23:0] exp_frames[$];
  string       exp_tags[$];
  logic [15:0] exp_rd[$];
  logic [23:0] resp_word = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // DAC-side model: capture on falling edge, drive on rising edge
  logic [23:0] cap, tx;
  int          nbits;
  longint      last_edge, min_d, max_d, last_fall;
  int          cs_rises = 0;
  bit          gap_due = 0;

  always @(posedge spi_cs) begin
    if (rst_n) begin
      cs_rises++;
      if (gap_due) begin
        check(($time - last_fall) >= GAP * 10, "R6 gap", $time - last_fall, GAP * 10);
        gap_due = 0;
      end
      cap = '0; nbits = 0; tx = resp_word;
      last_edge = $time; min_d = 64'h7fffffff; max_d = 0;
    end
  end

  task automatic note_edge();
    longint d;
    d = $time - last_edge;
    if (d < min_d) min_d = d;
    if (d > max_d) max_d = d;
    last_edge = $time;
  endtask

  always @(posedge spi_sclk) begin
    if (rst_n && spi_cs) begin
      note_edge();
      spi_miso <= tx[23];
      tx = {tx[22:0], 1'b0};
    end
  end

  always @(negedge spi_sclk) begin
    if (rst_n && spi_cs) begin
      note_edge();
      cap = {cap[22:0], spi_mosi};
      nbits++;
    end
  end

  always @(negedge spi_cs) begin
    if (rst_n) begin
      note_edge();
      last_fall = $time;
      if (exp_frames.size() == 0) begin
        check(0, "R3 unexpected frame", cap, 0);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_frames.pop_front();
        t = exp_tags.pop_front();
        check(cap == e, t, cap, e);
        check(nbits == 24, "R4 clock count", nbits, 24);
        check(min_d == HALF_NS && max_d == HALF_NS, "R4 half period", max_d, HALF_NS);
        gap_due = cap[22];
      end
    end
  end

  // readback monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_rd.size() == 0) check(0, "R7 unexpected rd_valid", rd_data, 0);
      else begin
        logic [15:0] e;
        e = exp_rd.pop_front();
        check(rd_data == e, "R7 rd_data", rd_data, e);
      end
    end
  end

  function automatic logic [23:0] raw_word(input logic [1:0] m, input logic [5:0] c,
                                           input logic r, input logic [15:0] d);
    return {1'b0, r, 1'b0, c[4:0], m, d[13:0]};
  endfunction

  task automatic issue(input logic [2:0] op, input logic [1:0] m, input logic [5:0] c,
                       input logic r, input logic [15:0] d, input logic [23:0] resp,
                       input logic [23:0] exp_w, input string tag);
    bit ok;
    bit rd;
    int rises0;
    ok = (op == 3'd0) ? (c < 6'd40) : (op <= 3'd4);
    rd = (op == 3'd0) && r;
    if (ok) begin
      exp_frames.push_back(exp_w); exp_tags.push_back(tag);
      if (rd) begin
        exp_frames.push_back(24'h0); exp_tags.push_back("R6 nop frame");
        exp_rd.push_back(resp[15:0]);
      end
    end
    resp_word = resp;
    while (!req_ready) @(negedge clk);
    rises0 = cs_rises;
    req_op = op; req_mode = m; req_chan = c; req_read = r; req_data = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(cmd_reject == !ok, "R3 reject flag", cmd_reject, !ok);
    if (!ok) begin
      repeat (300) @(negedge clk);
      check(cs_rises == rises0, "R3 no frame", cs_rises, rises0);
      check(req_ready == 1'b1, "R3 ready kept", req_ready, 1);
    end else begin
      check(req_ready == 1'b0, "R8 busy after accept", req_ready, 0);
      if (rd) begin
        @(negedge spi_cs);
        repeat (20) @(negedge clk);
        check(req_ready == 1'b0 && spi_cs == 1'b0, "R8 busy in gap", req_ready, 0);
      end
      while (!req_ready) @(negedge clk);
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(spi_cs == 0 && spi_sclk == 0 && spi_mosi == 0, "R10 bus idle", {spi_cs, spi_sclk, spi_mosi}, 0);
    check(req_ready == 1 && rd_valid == 0 && cmd_reject == 0, "R10 ctrl idle",
          {req_ready, rd_valid, cmd_reject}, 3'b100);

    // R1 raw writes
    issue(3'd0, 2'd3, 6'd5, 1'b0, 16'h1234, 24'h0, raw_word(2'd3, 6'd5, 1'b0, 16'h1234), "R1 data write");
    issue(3'd0, 2'd2, 6'd39, 1'b0, 16'hFFFF, 24'h0, 24'h07BFFF, "R2 mask ch39");
    issue(3'd0, 2'd1, 6'd0, 1'b0, 16'hC000, 24'h0, 24'h004000, "R2 mask high bits");
    issue(3'd0, 2'd0, 6'd31, 1'b0, 16'h2AAA, 24'h0, raw_word(2'd0, 6'd31, 1'b0, 16'h2AAA), "R1 special write");

    // R3 refused commands
    issue(3'd0, 2'd3, 6'd40, 1'b0, 16'h0001, 24'h0, 24'h0, "R3 ch40");
    issue(3'd0, 2'd3, 6'd63, 1'b1, 16'h0001, 24'h0, 24'h0, "R3 ch63");
    issue(3'd5, 2'd0, 6'd0, 1'b0, 16'h0000, 24'h0, 24'h0, "R3 op5");
    issue(3'd7, 2'd0, 6'd0, 1'b0, 16'h0000, 24'h0, 24'h0, "R3 op7");

    // R6 R7 readbacks
    issue(3'd0, 2'd1, 6'd17, 1'b1, 16'h0000, 24'hA5C3E1, 24'h514000, "R6 read command");
    issue(3'd0, 2'd0, 6'd12, 1'b1, 16'h3FFF, 24'hFF1400, 24'h4C3FFF, "R6 read ctrl");

    // R9 helpers
    issue(3'd1, 2'd3, 6'd9, 1'b0, 16'hFFFF, 24'h0, 24'h022000, "R9 soft clear");
    issue(3'd2, 2'd2, 6'd1, 1'b0, 16'h0000, 24'h0, 24'h0F211F, "R9 soft reset");
    issue(3'd3, 2'd1, 6'd3, 1'b1, 16'h1111, 24'h0, 24'h0C1400, "R9 ctrl 2.5V");
    issue(3'd4, 2'd3, 6'd50, 1'b1, 16'h0000, 24'h0, 24'h0C0400, "R9 ctrl 1.25V");

    repeat (50) @(negedge clk);
    check(exp_frames.size() == 0, "R1 frames drained", exp_frames.size(), 0);
    check(exp_rd.size() == 0, "R7 reads drained", exp_rd.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule